// File: doc/BRIEF.md
# Coprocessor Task Request Flag Controller

This block collects start requests for eight hardware tasks of a coprocessor and decides which task runs next. Each task watches one peripheral interrupt line, picked by its own 4-bit source select field. A rising edge on the chosen line marks the task pending. Software can also mark a task pending by writing a force register. An acknowledge path sets a task's pending flag only while that path is enabled in the control register.

A request that finds its task already pending sets that task's overflow bit. When the engine is idle, the lowest-numbered task that is both pending and enabled is granted. The grant is a one-cycle start pulse carrying the task number, and the task's flag drops on the same edge. The engine reports completion through a done input, and only then can another task be granted.

Software reaches the block through a small word-wide register bus with combinational read data. The source select, force and control registers change only while a write-unlock input is high.

Top module: `task_irq_ctrl`

## Requirements
- R1: For tasks 0-2 and 5-7 (numbered from 0), select field value 4'b0000 routes that task's ADC line (adc_irq[t]) and 4'b0010 routes its PWM line (pwm_irq[t]). Every other value, including any value with bit 0 set, routes nothing. Field t occupies bits [4t+3:4t] of register address 0.
- R2: For tasks 3 and 4, the select field also accepts 4'b0100, which routes the shared encoder line qep_irq, and 4'b1000, which routes the shared capture line cap_irq. Values 4'b0101, 4'b1100 and every other unlisted value route nothing.
- R3: A rising edge (low in one cycle, high in the next) on a task's routed line sets its flag at the next clock edge. A line held high sets the flag once and causes no further effect. Flags read at address 4, bit t for task t.
- R4: A rising edge that arrives while the task's flag is already set also sets the task's overflow bit (address 5, bit t). Writing 1 to bit t at address 6 clears that overflow bit.
- R5: Writing 1 to bit t at address 2 (force) sets flag t. When ack_valid is high and control bit 0 (address 7) is 1, flag ack_num is set. While that control bit is 0, the acknowledge input has no effect.
- R6: Writing 1 to bit t at address 3 clears flag t. Writes to address 4 have no effect. If a set and a clear reach the same flag in one cycle, the flag ends up set.
- R7: When no task is running, the lowest-numbered task that is both pending and enabled (address 1, bit t) is granted. start_valid is high for exactly one cycle with start_num equal to the task number, and that task's flag is cleared on the same edge.
- R8: After a start, no further start is issued until task_done has been seen. A pending task that is not enabled keeps its flag and is granted once it is enabled.
- R9: Writes to addresses 0 (select), 2 (force) and 7 (control) take effect only while wr_unlock is high. Otherwise they are ignored.
- R10: After reset, every select field, enable, flag, overflow and control bit reads as 0, and start_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wr_unlock | input | 1 | Permits writes to the select, force and control registers |
| adc_irq | input | 8 | Per-task ADC interrupt lines |
| pwm_irq | input | 8 | Per-task PWM interrupt lines |
| qep_irq | input | 1 | Shared encoder interrupt line |
| cap_irq | input | 1 | Shared capture interrupt line |
| ack_valid | input | 1 | Acknowledge-path request strobe |
| ack_num | input | 3 | Task number for the acknowledge path |
| task_done | input | 1 | Engine reports the running task finished |
| start_valid | output | 1 | One-cycle task start pulse |
| start_num | output | 3 | Number of the task being started |

## Verification
The bench walks the sparse select encodings for every kind of task. A decoder that treats encoder and capture codes as legal on the wrong tasks, or maps 4'b0101 to a source, would set a flag where none is expected. It holds a request line high over several cycles and then re-pulses it, so a level-sensitive detector would raise a false overflow, and a missing overflow path would stay silent. It drives a clear write in the same cycle as a new request, then checks the grant order, the gap until done, and the behaviour of a pending but disabled task. A flipped priority, a double start, or a flag lost to a clear would each show up as a wrong flag or start value.

// File: rtl/tic_pkg.sv
package tic_pkg;

  localparam int SEL_W = 4;

  localparam logic [2:0] ADDR_SEL    = 3'd0;
  localparam logic [2:0] ADDR_EN     = 3'd1;
  localparam logic [2:0] ADDR_FORCE  = 3'd2;
  localparam logic [2:0] ADDR_CLR    = 3'd3;
  localparam logic [2:0] ADDR_FLAGS  = 3'd4;
  localparam logic [2:0] ADDR_OVF    = 3'd5;
  localparam logic [2:0] ADDR_OVFCLR = 3'd6;
  localparam logic [2:0] ADDR_CTRL   = 3'd7;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_ADC,
    SRC_PWM,
    SRC_QEP,
    SRC_CAP
  } src_kind_e;

  // Sparse select decode; ext marks a task that may also take encoder/capture.
  function automatic src_kind_e decode_src(input logic ext, input logic [SEL_W-1:0] sel);
    src_kind_e k;
    k = SRC_NONE;
    if (sel == 4'b0000)             k = SRC_ADC;
    else if (sel == 4'b0010)        k = SRC_PWM;
    else if (ext && sel == 4'b0100) k = SRC_QEP;
    else if (ext && sel == 4'b1000) k = SRC_CAP;
    return k;
  endfunction

  function automatic logic route_level(input src_kind_e k, input logic adc, input logic pwm,
                                       input logic qep, input logic cap);
    logic v;
    case (k)
      SRC_ADC: v = adc;
      SRC_PWM: v = pwm;
      SRC_QEP: v = qep;
      SRC_CAP: v = cap;
      default: v = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tic_src_mux.sv
module tic_src_mux
  import tic_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int EXT_LO    = 3,
  parameter int EXT_HI    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_TASKS*SEL_W-1:0] sel_flat,
  input  logic [NUM_TASKS-1:0]       adc,
  input  logic [NUM_TASKS-1:0]       pwm,
  input  logic                       qep,
  input  logic                       cap,
  output logic [NUM_TASKS-1:0]       rise
);

  logic [NUM_TASKS-1:0] level;
  logic [NUM_TASKS-1:0] level_q;

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    localparam bit IsExt = (t >= EXT_LO) && (t <= EXT_HI);
    assign level[t] = route_level(decode_src(IsExt, sel_flat[t*SEL_W +: SEL_W]),
                                  adc[t], pwm[t], qep, cap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;

  // R3: an edge is never reported on two consecutive cycles for one task
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/tic_flag_bank.sv
module tic_flag_bank #(
  parameter int NUM_TASKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TASKS-1:0] rise,
  input  logic [NUM_TASKS-1:0] force_set,
  input  logic [NUM_TASKS-1:0] ack_set,
  input  logic [NUM_TASKS-1:0] sw_clr,
  input  logic [NUM_TASKS-1:0] start_clr,
  input  logic [NUM_TASKS-1:0] ovf_clr,
  output logic [NUM_TASKS-1:0] flags,
  output logic [NUM_TASKS-1:0] ovf
);

  logic [NUM_TASKS-1:0] set_all;
  logic [NUM_TASKS-1:0] clr_all;
  logic [NUM_TASKS-1:0] ovf_hit;

  assign set_all = rise | force_set | ack_set;
  assign clr_all = sw_clr | start_clr;
  assign ovf_hit = rise & flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ovf   <= '0;
    end else begin
      flags <= (flags & ~clr_all) | set_all;
      ovf   <= (ovf & ~ovf_clr) | ovf_hit;
    end
  end

  // R3: a detected edge leaves the flag set
  p_edge_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flags & $past(rise)) == $past(rise)));

  // R4: an edge onto a pending flag records overflow
  p_overflow_on_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & flags)) |=> ((ovf & $past(rise & flags)) == $past(rise & flags)));

  // R6: a clear without a competing set empties the flag
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_clr & ~rise & ~force_set & ~ack_set)) |=>
      ((flags & $past(sw_clr & ~rise & ~force_set & ~ack_set)) == '0));

endmodule

// File: rtl/tic_arbiter.sv
module tic_arbiter #(
  parameter int NUM_TASKS = 8,
  localparam int IDX_W    = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TASKS-1:0] eligible,
  input  logic                 busy,
  output logic                 grant_valid,
  output logic [IDX_W-1:0]     grant_idx
);

  // Lowest set index wins: scan from the top so the last hit is the lowest.
  function automatic logic [IDX_W-1:0] first_set(input logic [NUM_TASKS-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = NUM_TASKS - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  assign grant_valid = !busy && (|eligible);
  assign grant_idx   = first_set(eligible);

  // R7: the granted task is eligible and no lower-numbered task is
  p_grant_highest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (eligible[grant_idx] &&
                     ((eligible & ((NUM_TASKS'(1) << grant_idx) - NUM_TASKS'(1))) == '0)));

endmodule

// File: rtl/task_irq_ctrl.sv
module task_irq_ctrl
  import tic_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int EXT_LO    = 3,
  parameter int EXT_HI    = 4,
  localparam int IDX_W    = $clog2(NUM_TASKS),
  localparam int DATA_W   = NUM_TASKS * SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 wr_unlock,
  input  logic [NUM_TASKS-1:0] adc_irq,
  input  logic [NUM_TASKS-1:0] pwm_irq,
  input  logic                 qep_irq,
  input  logic                 cap_irq,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_num,
  input  logic                 task_done,
  output logic                 start_valid,
  output logic [IDX_W-1:0]     start_num
);

  localparam int PAD_W = DATA_W - NUM_TASKS;

  logic [DATA_W-1:0]    sel_q;
  logic [NUM_TASKS-1:0] en_q;
  logic                 ack_en_q;
  logic                 running_q;
  logic                 start_q;
  logic [IDX_W-1:0]     start_num_q;

  logic [NUM_TASKS-1:0] rise_w, flags_w, ovf_w, eligible_w;
  logic [NUM_TASKS-1:0] force_w, ack_w, swclr_w, startclr_w, ovfclr_w;
  logic                 grant_valid_w;
  logic [IDX_W-1:0]     grant_idx_w;
  logic                 wr_sel_w, wr_force_w, wr_ctrl_w;

  // Named write events, protected ones gated by wr_unlock.
  assign wr_sel_w   = bus_wr && wr_unlock && (bus_addr == ADDR_SEL);
  assign wr_force_w = bus_wr && wr_unlock && (bus_addr == ADDR_FORCE);
  assign wr_ctrl_w  = bus_wr && wr_unlock && (bus_addr == ADDR_CTRL);

  assign force_w    = wr_force_w ? bus_wdata[NUM_TASKS-1:0] : '0;
  assign swclr_w    = (bus_wr && bus_addr == ADDR_CLR) ? bus_wdata[NUM_TASKS-1:0] : '0;
  assign ovfclr_w   = (bus_wr && bus_addr == ADDR_OVFCLR) ? bus_wdata[NUM_TASKS-1:0] : '0;
  assign ack_w      = (ack_valid && ack_en_q) ? (NUM_TASKS'(1) << ack_num) : '0;
  assign startclr_w = grant_valid_w ? (NUM_TASKS'(1) << grant_idx_w) : '0;
  assign eligible_w = flags_w & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      en_q     <= '0;
      ack_en_q <= 1'b0;
    end else begin
      if (wr_sel_w) sel_q <= bus_wdata;
      if (bus_wr && bus_addr == ADDR_EN) en_q <= bus_wdata[NUM_TASKS-1:0];
      if (wr_ctrl_w) ack_en_q <= bus_wdata[0];
    end
  end

  tic_src_mux #(.NUM_TASKS(NUM_TASKS), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_flat (sel_q),
    .adc      (adc_irq),
    .pwm      (pwm_irq),
    .qep      (qep_irq),
    .cap      (cap_irq),
    .rise     (rise_w)
  );

  tic_flag_bank #(.NUM_TASKS(NUM_TASKS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise_w),
    .force_set (force_w),
    .ack_set   (ack_w),
    .sw_clr    (swclr_w),
    .start_clr (startclr_w),
    .ovf_clr   (ovfclr_w),
    .flags     (flags_w),
    .ovf       (ovf_w)
  );

  tic_arbiter #(.NUM_TASKS(NUM_TASKS)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .eligible    (eligible_w),
    .busy        (running_q),
    .grant_valid (grant_valid_w),
    .grant_idx   (grant_idx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q   <= 1'b0;
      start_q     <= 1'b0;
      start_num_q <= '0;
    end else begin
      start_q <= grant_valid_w;
      if (grant_valid_w) begin
        running_q   <= 1'b1;
        start_num_q <= grant_idx_w;
      end else if (task_done) begin
        running_q <= 1'b0;
      end
    end
  end

  assign start_valid = start_q;
  assign start_num   = start_num_q;

  always_comb begin
    case (bus_addr)
      ADDR_SEL:   bus_rdata = sel_q;
      ADDR_EN:    bus_rdata = {{PAD_W{1'b0}}, en_q};
      ADDR_FLAGS: bus_rdata = {{PAD_W{1'b0}}, flags_w};
      ADDR_OVF:   bus_rdata = {{PAD_W{1'b0}}, ovf_w};
      ADDR_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, ack_en_q};
      default:    bus_rdata = '0;
    endcase
  end

  // R8: a start pulse lasts one cycle and is not repeated before done
  p_single_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |=> !start_valid);

  // R7: the started task was pending and enabled in the grant cycle
  p_start_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> ((($past(eligible_w) >> start_num) & NUM_TASKS'(1)) != '0));

  // R9: a locked select write leaves the select register untouched
  p_sel_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_unlock && bus_addr == ADDR_SEL) |=> $stable(sel_q));

  // R5: acknowledge path while disabled cannot raise a flag by itself
  p_ack_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_en_q && !bus_wr && rise_w == '0 && !flags_w[ack_num])
      |=> !flags_w[$past(ack_num)]);

endmodule

// File: tb/tb_task_irq_ctrl.sv
module tb_task_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wr_unlock = 1'b0;
  logic [7:0]  adc_irq = '0;
  logic [7:0]  pwm_irq = '0;
  logic        qep_irq = 1'b0;
  logic        cap_irq = 1'b0;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_num = '0;
  logic        task_done = 1'b0;
  logic        start_valid;
  logic [2:0]  start_num;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  task_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_unlock(wr_unlock),
    .adc_irq(adc_irq), .pwm_irq(pwm_irq), .qep_irq(qep_irq), .cap_irq(cap_irq),
    .ack_valid(ack_valid), .ack_num(ack_num), .task_done(task_done),
    .start_valid(start_valid), .start_num(start_num)
  );

  // Vector: [11:9] task, [8:5] select, [4:3] line (0 adc,1 pwm,2 enc,3 cap), [0] flag expected
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    {3'd0, 4'b0000, 2'd0, 2'b0, 1'b1},
    {3'd0, 4'b0010, 2'd1, 2'b0, 1'b1},
    {3'd0, 4'b0010, 2'd0, 2'b0, 1'b0},
    {3'd0, 4'b0011, 2'd1, 2'b0, 1'b0},
    {3'd2, 4'b0001, 2'd0, 2'b0, 1'b0},
    {3'd2, 4'b0100, 2'd2, 2'b0, 1'b0},
    {3'd3, 4'b0100, 2'd2, 2'b0, 1'b1},
    {3'd3, 4'b1000, 2'd3, 2'b0, 1'b1},
    {3'd3, 4'b0101, 2'd2, 2'b0, 1'b0},
    {3'd4, 4'b0100, 2'd2, 2'b0, 1'b1},
    {3'd4, 4'b1000, 2'd3, 2'b0, 1'b1},
    {3'd4, 4'b0101, 2'd3, 2'b0, 1'b0},
    {3'd4, 4'b1100, 2'd3, 2'b0, 1'b0},
    {3'd7, 4'b0010, 2'd1, 2'b0, 1'b1},
    {3'd7, 4'b1000, 2'd3, 2'b0, 1'b0},
    {3'd6, 4'b0000, 2'd0, 2'b0, 1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic unl);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; wr_unlock = unl;
    @(negedge clk);
    bus_wr = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(3'd0, d); chk(d, 32'h0, "R10 select");
    rd(3'd1, d); chk(d, 32'h0, "R10 enable");
    rd(3'd4, d); chk(d, 32'h0, "R10 flags");
    rd(3'd5, d); chk(d, 32'h0, "R10 overflow");
    rd(3'd7, d); chk(d, 32'h0, "R10 control");
    chk({31'b0, start_valid}, 32'h0, "R10 start");

    // R1 / R2 select decode table
    for (int i = 0; i < NV; i++) begin
      int t;
      logic [3:0] s;
      logic [31:0] selw;
      t = int'(VEC[i][11:9]);
      s = VEC[i][8:5];
      selw = (32'hFFFF_FFFF & ~(32'hF << (4 * t))) | (32'(s) << (4 * t));
      wr(3'd0, selw, 1'b1);
      wr(3'd3, 32'hFF, 1'b0);
      wr(3'd6, 32'hFF, 1'b0);
      @(negedge clk);
      case (VEC[i][4:3])
        2'd0: adc_irq[t] = 1'b1;
        2'd1: pwm_irq[t] = 1'b1;
        2'd2: qep_irq = 1'b1;
        default: cap_irq = 1'b1;
      endcase
      @(negedge clk);
      adc_irq = '0; pwm_irq = '0; qep_irq = 1'b0; cap_irq = 1'b0;
      rd(3'd4, d);
      chk(d, VEC[i][0] ? (32'h1 << t) : 32'h0, (t == 3 || t == 4) ? "R2 decode" : "R1 decode");
    end

    wr(3'd0, 32'h0, 1'b1);
    wr(3'd3, 32'hFF, 1'b0);
    wr(3'd6, 32'hFF, 1'b0);

    // R3 level held: one set, no overflow
    @(negedge clk); adc_irq[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd4, d); chk(d, 32'h1, "R3 flag from edge");
    rd(3'd5, d); chk(d, 32'h0, "R3 held level no overflow");
    adc_irq[0] = 1'b0;
    @(negedge clk); adc_irq[0] = 1'b1;
    @(negedge clk); adc_irq[0] = 1'b0;
    rd(3'd5, d); chk(d, 32'h1, "R4 overflow on pending");
    wr(3'd6, 32'h1, 1'b0);
    rd(3'd5, d); chk(d, 32'h0, "R4 overflow clear");

    // R6 set beats clear: edge and clear in the same cycle
    @(negedge clk);
    adc_irq[0] = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h1;
    @(negedge clk);
    adc_irq[0] = 1'b0; bus_wr = 1'b0;
    rd(3'd4, d); chk(d, 32'h1, "R6 set wins over clear");
    wr(3'd4, 32'h0, 1'b1);
    rd(3'd4, d); chk(d, 32'h1, "R6 flag register write ignored");
    wr(3'd3, 32'h1, 1'b0);
    rd(3'd4, d); chk(d, 32'h0, "R6 clear register");
    wr(3'd4, 32'hFF, 1'b1);
    rd(3'd4, d); chk(d, 32'h0, "R6 flag register write no set");

    // R9 locked writes
    wr(3'd0, 32'h2222_2222, 1'b0);
    rd(3'd0, d); chk(d, 32'h0, "R9 select locked");
    wr(3'd2, 32'h10, 1'b0);
    rd(3'd4, d); chk(d, 32'h0, "R9 force locked");
    wr(3'd7, 32'h1, 1'b0);
    rd(3'd7, d); chk(d, 32'h0, "R9 control locked");

    // R5 force and acknowledge path
    wr(3'd2, 32'h10, 1'b1);
    rd(3'd4, d); chk(d, 32'h10, "R5 force sets");
    wr(3'd3, 32'hFF, 1'b0);
    @(negedge clk); ack_valid = 1'b1; ack_num = 3'd6;
    @(negedge clk); ack_valid = 1'b0;
    rd(3'd4, d); chk(d, 32'h0, "R5 ack ignored while disabled");
    wr(3'd7, 32'h1, 1'b1);
    @(negedge clk); ack_valid = 1'b1; ack_num = 3'd6;
    @(negedge clk); ack_valid = 1'b0;
    rd(3'd4, d); chk(d, 32'h40, "R5 ack sets when enabled");
    wr(3'd3, 32'hFF, 1'b0);

    // R7 / R8 grant order and running gap
    wr(3'd2, 32'h26, 1'b1);
    wr(3'd1, 32'h24, 1'b0);
    chk({31'b0, start_valid}, 32'h0, "R7 no start before grant edge");
    @(negedge clk);
    chk({31'b0, start_valid}, 32'h1, "R7 start pulse");
    chk({29'b0, start_num}, 32'd2, "R7 highest priority task");
    rd(3'd4, d); chk(d, 32'h22, "R7 started flag cleared");
    @(negedge clk);
    chk({31'b0, start_valid}, 32'h0, "R7 pulse one cycle");
    repeat (3) @(negedge clk);
    chk({31'b0, start_valid}, 32'h0, "R8 no start while running");
    task_done = 1'b1;
    @(negedge clk); task_done = 1'b0;
    chk({31'b0, start_valid}, 32'h0, "R8 no start on done edge");
    @(negedge clk);
    chk({31'b0, start_valid}, 32'h1, "R8 next start after done");
    chk({29'b0, start_num}, 32'd5, "R8 next task number");
    task_done = 1'b1;
    @(negedge clk); task_done = 1'b0;
    repeat (3) @(negedge clk);
    chk({31'b0, start_valid}, 32'h0, "R8 disabled task not started");
    rd(3'd4, d); chk(d, 32'h02, "R8 disabled task stays pending");
    wr(3'd1, 32'h02, 1'b0);
    @(negedge clk);
    chk({31'b0, start_valid}, 32'h1, "R8 start once enabled");
    chk({29'b0, start_num}, 32'd1, "R8 enabled task number");

    summary();
    $finish;
  end

endmodule